// File: doc/BRIEF.md
# Flash Program Store Protection Controller

This block sits in front of an on-chip program flash array and decides whether each byte-write or page-erase request may proceed. A small control register holds two permission bits: one for writing and one for erasing. A lock byte stored in the last byte of user flash defines a protected region. Its bitwise inverse is a page count n. Pages 0 to n-1, each 512 bytes, are protected. When n is nonzero, the page that holds the lock byte is protected as well. Requests from untrusted sources (a debug path or unprotected code) must not touch a protected page. Trusted requests may, provided the permission bits allow the operation.

When a request is granted, the block issues a one-cycle command to the array. It then holds a busy signal for a programmable number of clocks, which stands in for the write or erase time. Any request it refuses produces a one-cycle violation pulse and has no other effect. The lock byte arrives from the array on `lock_src`. The block samples it once after reset and again after any completed operation that may have changed it. A combinational read-permission output applies the same lock region to reads.

Top module: `flash_guard`

## Requirements
- R1: A byte write is granted only when control bit 0 (write permission) is 1.
- R2: A page erase is granted only when control bit 0 and control bit 1 (erase permission) are both 1.
- R3: With lock byte L, n = ~L, and for an untrusted request every page index p = addr[ADDR_W-1:9] with p < n is refused. With L = 0xFD, addresses 0x0000–0x03FF are locked and 0x0400 is not.
- R4: When n is nonzero, the lock-byte page is refused to untrusted requests. For 64 KB this is 0xFA00–0xFBFF, with the lock byte at 0xFBFF. With L = 0xFF nothing is locked, and that includes the lock-byte page.
- R5: A trusted request ignores the lock region, but the permission bits still apply to it.
- R6: On the 64 KB build (ADDR_W = 16), every write or erase at 0xFC00–0xFFFF is refused, even a trusted one.
- R7: A refused request raises `violation` for exactly the next cycle. It produces no `grant`, no array command and no change to `ctl_state`.
- R8: A granted request raises `grant` for the next cycle. In that same cycle it issues `fl_we` (with `fl_addr`/`fl_data`) or `fl_erase` (with `fl_addr` aligned to its page). From that cycle, `busy` stays high for WRITE_CYCLES or ERASE_CYCLES cycles.
- R9: Any request presented while `busy` is high is refused.
- R10: The lock byte is sampled during a one-cycle busy period after reset. It is sampled again during one extra busy cycle after a write to the lock byte address, or after an erase of the lock-byte page.
- R11: `rd_allow` is 0 exactly when `rd_trusted` is 0 and `rd_addr` lies in a locked page.
- R12: `ctl_state` resets to 0 and takes `ctl_wdata` on a cycle with `ctl_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Load control register |
| ctl_wdata | input | 2 | Control value: bit 0 is write permission, bit 1 is erase permission |
| ctl_state | output | 2 | Current control register |
| req_valid | input | 1 | Request strobe |
| req_erase | input | 1 | 1 = page erase, 0 = byte write |
| req_addr | input | ADDR_W | Target address |
| req_data | input | 8 | Write data |
| req_trusted | input | 1 | Requester is trusted code |
| grant | output | 1 | Request accepted (one cycle) |
| violation | output | 1 | Request refused (one cycle) |
| busy | output | 1 | Operation or lock reload in progress |
| fl_we | output | 1 | Array byte-write command |
| fl_erase | output | 1 | Array page-erase command |
| fl_addr | output | ADDR_W | Array command address |
| fl_data | output | 8 | Array write data |
| lock_src | input | 8 | Current lock byte from the array |
| rd_addr | input | ADDR_W | Read address to check |
| rd_trusted | input | 1 | Reader is trusted code |
| rd_allow | output | 1 | Read permitted |

## Verification
The bench builds the 64 KB variant with WRITE_CYCLES = 3 and ERASE_CYCLES = 9. With the 64 KB array, both the reserved top kilobyte and the lock page at 0xFA00 can be exercised. The short cycle counts keep each busy window small enough to measure exactly, including the extra reload cycle. Random requests cover write and erase, trusted and untrusted sources, and reserved, locked, lock-page and free addresses. They are interleaved with changes to the lock byte and the control bits, so the lock decode is exercised across many counts. A mid-test reset shows that the lock region is rebuilt from the stored byte.

// File: rtl/fgd_pkg.sv
package fgd_pkg;
  typedef struct packed {
    logic erase_en;
    logic write_en;
  } fgd_ctl_t;

  localparam int unsigned PAGE_SHIFT = 9;
  localparam int unsigned TOP_RSV_BYTES = 1024;
endpackage

// File: rtl/fgd_lock_decode.sv
module fgd_lock_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LOCK_PAGE = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [7:0]        lock_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              req_locked,
  output logic              rd_locked
);
  localparam int unsigned PW = ADDR_W - fgd_pkg::PAGE_SHIFT;

  logic [7:0] cnt_q, cnt_d;

  function automatic logic in_lock(input logic [ADDR_W-1:0] a, input logic [7:0] n);
    logic [PW-1:0] pg;
    pg = a[ADDR_W-1:fgd_pkg::PAGE_SHIFT];
    return (n != 8'd0) && ((int'(pg) < int'(n)) || (int'(pg) == int'(LOCK_PAGE)));
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = ~lock_src;
  end

  // Until the first load the whole array counts as locked.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 8'hFF;
    else        cnt_q <= cnt_d;
  end

  assign req_locked = in_lock(req_addr, cnt_q);
  assign rd_locked  = in_lock(rd_addr, cnt_q);
endmodule

// File: rtl/fgd_busy_timer.sv
module fgd_busy_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  input  logic          touches_lock,
  output logic          busy,
  output logic          reload
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          touch_q, touch_d;
  logic          rel_q, rel_d;

  always_comb begin
    cnt_d   = cnt_q;
    touch_d = touch_q;
    rel_d   = 1'b0;
    if (start) begin
      cnt_d   = len;
      touch_d = touches_lock;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1) && touch_q) rel_d = 1'b1;
    end
  end

  // rel_q resets high so the lock byte is sampled right after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      touch_q <= 1'b0;
      rel_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      touch_q <= touch_d;
      rel_q   <= rel_d;
    end
  end

  assign busy   = (cnt_q != '0) || rel_q;
  assign reload = rel_q;
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned WRITE_CYCLES = 4,
  parameter int unsigned ERASE_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  output logic [1:0]        ctl_state,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              req_trusted,
  output logic              grant,
  output logic              violation,
  output logic              busy,
  output logic              fl_we,
  output logic              fl_erase,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_data,
  input  logic [7:0]        lock_src,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_trusted,
  output logic              rd_allow
);
  import fgd_pkg::*;

  localparam int unsigned FULL_BYTES = 2 ** ADDR_W;
  localparam int unsigned USER_BYTES = (ADDR_W == 16) ? FULL_BYTES - TOP_RSV_BYTES : FULL_BYTES;
  localparam int unsigned LOCK_ADDR  = USER_BYTES - 1;
  localparam int unsigned LOCK_PAGE  = LOCK_ADDR >> PAGE_SHIFT;
  localparam int unsigned MAX_CYC    = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW         = $clog2(MAX_CYC + 1);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rsync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  logic rst_sync_n;
  assign rst_sync_n = rsync_q[1];

  fgd_ctl_t ctl_q, ctl_d;
  logic req_locked, rd_locked, reload, tmr_busy;
  logic in_rsv, perm_ok, ok, touch;
  logic grant_d, viol_d, we_d, er_d;
  logic grant_q, viol_q, we_q, er_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [7:0] data_d, data_q;
  logic [CW-1:0] len;

  fgd_lock_decode #(.ADDR_W(ADDR_W), .LOCK_PAGE(LOCK_PAGE)) u_lock (
    .clk(clk), .rst_n(rst_sync_n), .load(reload), .lock_src(lock_src),
    .req_addr(req_addr), .rd_addr(rd_addr),
    .req_locked(req_locked), .rd_locked(rd_locked)
  );

  fgd_busy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .start(grant_d), .len(len),
    .touches_lock(touch), .busy(tmr_busy), .reload(reload)
  );

  generate
    if (USER_BYTES < FULL_BYTES) begin : g_rsv
      assign in_rsv = int'(req_addr) >= int'(USER_BYTES);
    end else begin : g_norsv
      assign in_rsv = 1'b0;
    end
  endgenerate

  always_comb begin
    perm_ok = ctl_q.write_en && (!req_erase || ctl_q.erase_en);
    ok      = !tmr_busy && perm_ok && !in_rsv && (req_trusted || !req_locked);
    touch   = req_erase ? (int'(req_addr >> PAGE_SHIFT) == int'(LOCK_PAGE))
                        : (int'(req_addr) == int'(LOCK_ADDR));
    len     = req_erase ? CW'(ERASE_CYCLES) : CW'(WRITE_CYCLES);
    grant_d = req_valid && ok;
    viol_d  = req_valid && !ok;
    we_d    = grant_d && !req_erase;
    er_d    = grant_d && req_erase;
    addr_d  = addr_q;
    data_d  = data_q;
    if (grant_d) begin
      addr_d = req_erase ? {req_addr[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}} : req_addr;
      data_d = req_data;
    end
    ctl_d = ctl_q;
    if (ctl_we) ctl_d = fgd_ctl_t'(ctl_wdata);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q   <= '0;
      grant_q <= 1'b0;
      viol_q  <= 1'b0;
      we_q    <= 1'b0;
      er_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      ctl_q   <= ctl_d;
      grant_q <= grant_d;
      viol_q  <= viol_d;
      we_q    <= we_d;
      er_q    <= er_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign ctl_state = ctl_q;
  assign grant     = grant_q;
  assign violation = viol_q;
  assign busy      = tmr_busy;
  assign fl_we     = we_q;
  assign fl_erase  = er_q;
  assign fl_addr   = addr_q;
  assign fl_data   = data_q;
  assign rd_allow  = rd_trusted || !rd_locked;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ctl_state,
  input logic              req_valid,
  input logic              req_erase,
  input logic [ADDR_W-1:0] req_addr,
  input logic              grant,
  input logic              violation,
  input logic              busy,
  input logic              fl_we,
  input logic              fl_erase
);
  assert_wr_perm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ctl_state[0]) |=> (violation && !grant));

  assert_er_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_erase && !ctl_state[1]) |=> !fl_erase);

  assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (ADDR_W == 16) && (int'(req_addr) >= 32'hFC00)) |=> !grant);

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(violation && (grant || fl_we || fl_erase)));

  assert_cmd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_we, fl_erase}) && (grant == (fl_we || fl_erase)));

  assert_grant_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> busy);

  assert_busy_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> (violation && !grant));
endmodule

bind flash_guard flash_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .ctl_state(ctl_state), .req_valid(req_valid),
  .req_erase(req_erase), .req_addr(req_addr), .grant(grant), .violation(violation),
  .busy(busy), .fl_we(fl_we), .fl_erase(fl_erase)
);

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;
  localparam int AW = 16;
  localparam int WC = 3;
  localparam int EC = 9;
  localparam int LOCK_ADDR = 16'hFBFF;
  localparam int LOCK_PAGE = LOCK_ADDR >> 9;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_we;
  logic [1:0] ctl_wdata, ctl_state;
  logic req_valid, req_erase, req_trusted;
  logic [AW-1:0] req_addr, fl_addr, rd_addr;
  logic [7:0] req_data, fl_data, lock_src;
  logic grant, violation, busy, fl_we, fl_erase, rd_trusted, rd_allow;

  always #4 clk = ~clk;

  flash_guard #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_state(ctl_state),
    .req_valid(req_valid), .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
    .req_trusted(req_trusted), .grant(grant), .violation(violation), .busy(busy),
    .fl_we(fl_we), .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_data(fl_data),
    .lock_src(lock_src), .rd_addr(rd_addr), .rd_trusted(rd_trusted), .rd_allow(rd_allow)
  );

  int nchk = 0;
  int nerr = 0;
  logic [1:0] m_ctl;
  logic [7:0] m_lock;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_locked(input int a);
    int n = int'(~m_lock) & 8'hFF;
    int p = a >> 9;
    return (n != 0) && ((p < n) || (p == LOCK_PAGE));
  endfunction

  function automatic bit m_ok(input bit er, input int a, input bit tr);
    if (!m_ctl[0]) return 0;
    if (er && !m_ctl[1]) return 0;
    if (a >= 16'hFC00) return 0;
    if (!tr && m_locked(a)) return 0;
    return 1;
  endfunction

  task automatic set_ctl(input logic [1:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    m_ctl = v;
    check(ctl_state == v, "R12 ctl load", ctl_state, v);
  endtask

  task automatic do_req(input bit er, input int a, input logic [7:0] d, input bit tr, input string tag);
    bit exp;
    bit touch;
    int cyc;
    exp = m_ok(er, a, tr);
    touch = er ? ((a >> 9) == LOCK_PAGE) : (a == LOCK_ADDR);
    @(negedge clk);
    req_valid = 1'b1; req_erase = er; req_addr = AW'(a); req_data = d; req_trusted = tr;
    @(negedge clk);
    req_valid = 1'b0;
    check(grant == exp && violation == !exp, tag, {grant, violation}, {exp, !exp});
    if (exp) begin
      if (er) begin
        check(fl_erase && !fl_we && fl_addr == AW'(a & 16'hFE00), "R8 erase cmd", fl_addr, a & 16'hFE00);
        if ((a >> 9) == LOCK_PAGE) lock_src = 8'hFF;
      end else begin
        check(fl_we && !fl_erase && fl_addr == AW'(a) && fl_data == d, "R8 write cmd", fl_addr, a);
        if (a == LOCK_ADDR) lock_src = d;
      end
      cyc = 0;
      while (busy && cyc < 64) begin
        cyc++;
        @(negedge clk);
      end
      check(cyc == (er ? EC : WC) + int'(touch), "R8 R10 busy length", cyc, (er ? EC : WC) + int'(touch));
      m_lock = lock_src;
    end else begin
      check(!fl_we && !fl_erase && ctl_state == m_ctl, "R7 no side effect", ctl_state, m_ctl);
      @(negedge clk);
      check(!violation, "R7 single pulse", violation, 0);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ctl_state == 2'b00 && !grant && !violation && busy, "R12 R10 reset state",
          {ctl_state, grant, violation, busy}, 5'b00001);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy, "R10 reload done", busy, 0);
    m_ctl = 2'b00;
    m_lock = lock_src;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    ctl_we = 0; ctl_wdata = 0; req_valid = 0; req_erase = 0; req_addr = 0;
    req_data = 0; req_trusted = 0; rd_addr = 0; rd_trusted = 0; lock_src = 8'hFF;
    do_reset();

    do_req(0, 16'h1000, 8'h11, 0, "R1 write without permission");
    set_ctl(2'b01);
    do_req(0, 16'h0010, 8'h22, 0, "R4 unlocked 0xFF write");
    do_req(1, 16'h2000, 8'h00, 1, "R2 erase needs both bits");
    do_req(0, 16'hFA20, 8'h33, 0, "R4 lock page free when n=0");
    set_ctl(2'b11);
    do_req(1, 16'h2040, 8'h00, 0, "R2 erase with both bits");
    do_req(0, LOCK_ADDR, 8'hFD, 1, "R10 program lock byte");
    do_req(0, 16'h0300, 8'h44, 0, "R3 page 1 locked");
    do_req(0, 16'h0000, 8'h44, 0, "R3 page 0 locked");
    do_req(0, 16'h0400, 8'h55, 0, "R3 page 2 free");
    do_req(0, 16'hFA10, 8'h55, 0, "R4 lock page locked");
    do_req(1, 16'h0200, 8'h00, 0, "R4 erase locked page");
    do_req(0, 16'h0300, 8'h66, 1, "R5 trusted bypass");
    do_req(0, 16'hFC00, 8'h66, 1, "R6 reserved write");
    do_req(1, 16'hFE00, 8'h00, 1, "R6 reserved erase");
    set_ctl(2'b00);
    do_req(0, 16'h0300, 8'h66, 1, "R5 trusted still needs permission");
    set_ctl(2'b11);

    rd_addr = 16'h01FF; rd_trusted = 0; #1;
    check(!rd_allow, "R11 read locked", rd_allow, 0);
    rd_addr = 16'hFA00; #1;
    check(!rd_allow, "R11 read lock page", rd_allow, 0);
    rd_addr = 16'h0400; #1;
    check(rd_allow, "R11 read free", rd_allow, 1);
    rd_addr = 16'h0000; rd_trusted = 1; #1;
    check(rd_allow, "R11 trusted read", rd_allow, 1);

    // Back-to-back: second request lands while busy.
    @(negedge clk);
    req_valid = 1; req_erase = 0; req_addr = 16'h0800; req_data = 8'h77; req_trusted = 0;
    @(negedge clk);
    check(grant, "R8 first grant", grant, 1);
    req_addr = 16'h0801;
    @(negedge clk);
    req_valid = 0;
    check(violation && !grant, "R9 busy reject", {grant, violation}, 2'b01);
    while (busy) @(negedge clk);

    do_reset();
    check(ctl_state == 2'b00, "R12 reset ctl", ctl_state, 0);
    set_ctl(2'b01);
    do_req(0, 16'h0100, 8'h01, 0, "R10 lock resampled after reset");

    set_ctl(2'b11);
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      int a;
      bit er = $urandom_range(0, 3) == 0;
      bit tr = $urandom_range(0, 1) == 1;
      logic [7:0] d = 8'($urandom);
      case (sel)
        0: a = LOCK_ADDR;
        1: a = 16'hFA00 + $urandom_range(0, 511);
        2: a = 16'hFC00 + $urandom_range(0, 1023);
        3, 4: a = $urandom_range(0, 16'h0BFF);
        default: a = $urandom_range(0, 16'hFFFF);
      endcase
      if (sel == 0) begin
        er = 0;
        d = ($urandom_range(0, 1) == 1) ? 8'hFF - 8'($urandom_range(0, 6)) : d;
      end
      if ($urandom_range(0, 15) == 0) set_ctl(2'($urandom_range(0, 3)));
      do_req(er, a, d, tr, "R3 R4 R5 random request");
      if (i % 37 == 0) set_ctl(2'b11);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule